// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block carries data words from a write clock domain into a read clock domain whose clock has no fixed relation to the write clock. Write and read pointers each carry one extra wrap bit. They cross between the domains in Gray code through a chain of synchronizer flops whose length is a parameter. Each side works out its own occupancy from its local pointer and the synchronized copy of the remote one. Because the remote copy is always somewhat stale, full and empty are pessimistic: each may stay asserted for a few cycles after the other side has made room or added data, but neither ever allows an overrun.

A parameter sets the read side to one of two modes. In standard mode a read enable returns the word one read clock later, together with a data-valid pulse, and one storage slot is never used. In first-word-fall-through mode an output stage always presents the oldest word with data-valid high, and a read enable consumes it. That stage adds one to the capacity. The write side reports full, almost-full, threshold-full, overflow, write acknowledge and its word count. The read side reports empty, almost-empty, threshold-empty, underflow, data-valid and its word count.

A single reset input, sampled on the write clock, starts a four-phase handshake with the read domain. Each domain holds its own reset-busy output high until both sides have cleared their pointers.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with no loss and no duplication, in both read modes.
- R2: The FIFO holds at most DEPTH-1 words in standard mode (FWFT=0) and DEPTH+1 words in fall-through mode (FWFT=1); full is high once that many words are stored and no write reads from the other side has been seen.
- R3: A write enable while full is dropped: stored contents and the write count do not change, and overflow is high for exactly the next write clock cycle.
- R4: A read enable while empty is dropped and leaves the FIFO unchanged; underflow is high for exactly the next read clock cycle.
- R5: wr_ack is high in the write clock cycle after an accepted write and low after a cycle with no accepted write.
- R6: prog_full is high while the write-side count is at or above PFULL_TH; prog_empty is high while the read-side count is at or below PEMPTY_TH.
- R7: almost_full is high when the write-side count is one below the write-side limit (DEPTH-1 in standard mode, DEPTH in fall-through mode); almost_empty is high when the read-side count equals 1.
- R8: In fall-through mode the oldest word is on rd_data with data_valid high before any read enable, it stays there until a read enable consumes it, and a read enable while it is present pops it.
- R9: In standard mode an accepted read puts the word on rd_data with data_valid high in the next read clock cycle; data_valid is low after a cycle with no accepted read.
- R10: Asserting rst (even for one write clock) raises wr_rst_busy on the next write clock edge and rd_rst_busy a few read clocks later. wr_rst_busy falls only after rd_rst_busy has fallen. Afterwards the FIFO is empty, both counts are 0, empty and prog_empty are high and data_valid is low.
- R11: While wr_rst_busy is high, full, almost_full and prog_full equal the FULL_RST_VAL parameter.
- R12: wr_count is the number of words stored in memory as seen by the write side, which excludes the word held in the fall-through output stage. rd_count is the number of words the read side can still deliver, which includes that stage. Both counts are exact once the other side has been idle for longer than the synchronizer latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Active-high reset, synchronous to wr_clk |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No further write is accepted |
| almost_full | output | 1 | Exactly one more write fits |
| prog_full | output | 1 | Write count at or above PFULL_TH |
| overflow | output | 1 | Previous write request was dropped |
| wr_ack | output | 1 | Previous write request was accepted |
| wr_count | output | log2(DEPTH)+1 | Write-side word count |
| wr_rst_busy | output | 1 | Write domain is in reset |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Output word |
| data_valid | output | 1 | rd_data holds a valid word |
| empty | output | 1 | No word available to read |
| almost_empty | output | 1 | Exactly one word left to read |
| prog_empty | output | 1 | Read count at or below PEMPTY_TH |
| underflow | output | 1 | Previous read request was dropped |
| rd_count | output | log2(DEPTH)+1 | Read-side word count |
| rd_rst_busy | output | 1 | Read domain is in reset |

## Verification
The bench fills the FIFO to its exact mode-dependent capacity and then tries one more write. A design that miscounts the fall-through stage or the reserved slot would report full one word early or late, and a design that does not guard the write would overwrite the oldest word, which the in-order drain then exposes. Every single-word step checks the almost and threshold flags, so an off-by-one in any comparison shows up at a known count. It also reads while empty, where a missing guard would either deliver an old word or move the read pointer past the write pointer. Long runs with random enables on the unrelated clocks, and a reset pulse only one write clock long in the middle of a transfer, expose pointer-crossing errors and a reset handshake that can let the write side leave reset before the read side.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

   // Words the write side may hold in memory before it reports full.
   function automatic int unsigned wr_limit(input int unsigned depth, input bit fwft);
      return fwft ? depth : depth - 1;
   endfunction

   // Words the whole FIFO can hold, output stage included.
   function automatic int unsigned total_cap(input int unsigned depth, input bit fwft);
      return fwft ? depth + 1 : depth - 1;
   endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_ptr_xing.sv
module dcf_ptr_xing #(
   parameter int PW     = 5,
   parameter int STAGES = 2
) (
   input  logic          src_clk,
   input  logic          src_rst,
   input  logic [PW-1:0] src_bin,
   input  logic          dst_clk,
   input  logic          dst_rst,
   output logic [PW-1:0] dst_bin
);
   logic [PW-1:0] gray_q;
   logic [PW-1:0] gray_s;

   // Gray copy is registered in the source domain so only one bit moves per edge.
   always_ff @(posedge src_clk) begin
      if (src_rst) gray_q <= '0;
      else         gray_q <= src_bin ^ (src_bin >> 1);
   end

   dcf_sync #(.W(PW), .STAGES(STAGES)) u_sync (
      .clk (dst_clk),
      .rst (dst_rst),
      .d   (gray_q),
      .q   (gray_s)
   );

   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = PW - 1; i >= 0; i--) begin
         acc        = acc ^ gray_s[i];
         dst_bin[i] = acc;
      end
   end

   // R1: the crossing word never changes in more than one bit per source edge
   p_gray_single_step_r1: assert property (@(posedge src_clk) disable iff (src_rst)
      $countones(gray_q ^ $past(gray_q)) <= 1)
      else $error("gray pointer moved by more than one bit");
endmodule

// File: rtl/dcf_reset_hs.sv
module dcf_reset_hs #(
   parameter int STAGES = 2
) (
   input  logic wr_clk,
   input  logic rd_clk,
   input  logic rst,
   output logic wr_busy,
   output logic rd_busy
);
   logic req_q;
   logic busy_q;
   logic ack_s;

   dcf_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
      .clk (rd_clk),
      .rst (1'b0),
      .d   (req_q),
      .q   (rd_busy)
   );

   dcf_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
      .clk (wr_clk),
      .rst (1'b0),
      .d   (rd_busy),
      .q   (ack_s)
   );

   // Four phases: request up, read side acknowledges, request down, acknowledge down.
   always_ff @(posedge wr_clk) begin
      if (rst) begin
         req_q  <= 1'b1;
         busy_q <= 1'b1;
      end else begin
         if (req_q && ack_s)   req_q  <= 1'b0;
         if (!req_q && !ack_s) busy_q <= 1'b0;
      end
   end

   assign wr_busy = busy_q;

   // R10: read domain still in reset implies write domain still reports busy
   p_wr_busy_covers_rd_r10: assert property (@(posedge wr_clk) disable iff (rst)
      ack_s |-> wr_busy)
      else $error("write side left reset before read side");
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] ram [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) ram[waddr] <= wdata;
   end

   assign rdata = ram[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
   parameter int ADDR_W   = 4,
   parameter int LIMIT    = 15,
   parameter int PFULL_TH = 12,
   parameter bit FULL_RST = 1'b0
) (
   input  logic            clk,
   input  logic            busy,
   input  logic            wr_en,
   input  logic [ADDR_W:0] rd_ptr_s,
   output logic [ADDR_W:0] ptr,
   output logic            accept,
   output logic            full,
   output logic            almost_full,
   output logic            prog_full,
   output logic            overflow,
   output logic            wr_ack,
   output logic [ADDR_W:0] count
);
   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] LIM_V = PW'(LIMIT);
   localparam logic [PW-1:0] AF_V  = PW'(LIMIT - 1);
   localparam logic [PW-1:0] PF_V  = PW'(PFULL_TH);

   logic full_raw;

   assign count    = ptr - rd_ptr_s;
   assign full_raw = (count >= LIM_V);
   assign accept   = wr_en && !full_raw && !busy;

   always_ff @(posedge clk) begin
      if (busy) begin
         ptr      <= '0;
         wr_ack   <= 1'b0;
         overflow <= 1'b0;
      end else begin
         ptr      <= ptr + PW'(accept);
         wr_ack   <= accept;
         overflow <= wr_en && full_raw;
      end
   end

   assign full        = busy ? FULL_RST : full_raw;
   assign almost_full = busy ? FULL_RST : (count == AF_V);
   assign prog_full   = busy ? FULL_RST : (count >= PF_V);

   // R3: a write while full leaves the pointer alone and flags overflow next cycle
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (busy)
      (wr_en && full) |=> (overflow && $stable(ptr)))
      else $error("write while full was not dropped");

   // R5: an accepted write advances the pointer by one and is acknowledged
   p_write_ack_r5: assert property (@(posedge clk) disable iff (busy)
      (wr_en && !full) |=> (wr_ack && (ptr == $past(ptr) + 1'b1)))
      else $error("accepted write not acknowledged");

   // R2: occupancy seen by the write side never passes its limit
   p_wr_count_bound_r2: assert property (@(posedge clk) disable iff (busy)
      count <= LIM_V)
      else $error("write-side count beyond limit");
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter bit FWFT      = 1'b0,
   parameter int CAP       = 15,
   parameter int PEMPTY_TH = 4
) (
   input  logic              clk,
   input  logic              busy,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wr_ptr_s,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W:0]   ptr,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_valid,
   output logic              empty,
   output logic              almost_empty,
   output logic              prog_empty,
   output logic              underflow,
   output logic [ADDR_W:0]   count
);
   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] PE_V  = PW'(PEMPTY_TH);
   localparam logic [PW-1:0] CAP_V = PW'(CAP);

   logic [PW-1:0] mem_cnt;
   assign mem_cnt = wr_ptr_s - ptr;

   generate
      if (FWFT) begin : g_fwft
         logic head_q;
         logic pop;
         logic load;

         assign pop  = rd_en && head_q;
         assign load = (mem_cnt != '0) && (!head_q || pop);

         always_ff @(posedge clk) begin
            if (busy) begin
               head_q  <= 1'b0;
               rd_data <= '0;
               ptr     <= '0;
            end else if (load) begin
               head_q  <= 1'b1;
               rd_data <= mem_rdata;
               ptr     <= ptr + 1'b1;
            end else if (pop) begin
               head_q  <= 1'b0;
            end
         end

         assign data_valid = head_q;
         assign empty      = !head_q;
         assign count      = mem_cnt + PW'(head_q);

         // R8: an unconsumed head word is held steady on the output
         p_fwft_head_hold_r8: assert property (@(posedge clk) disable iff (busy)
            (data_valid && !rd_en) |=> (data_valid && $stable(rd_data)))
            else $error("fall-through head changed without a read");
      end else begin : g_std
         logic take;
         logic dv_q;

         assign take = rd_en && (mem_cnt != '0);

         always_ff @(posedge clk) begin
            if (busy) begin
               dv_q    <= 1'b0;
               rd_data <= '0;
               ptr     <= '0;
            end else begin
               dv_q <= take;
               ptr  <= ptr + PW'(take);
               if (take) rd_data <= mem_rdata;
            end
         end

         assign data_valid = dv_q;
         assign empty      = (mem_cnt == '0);
         assign count      = mem_cnt;

         // R9: an accepted read yields valid data one cycle later
         p_std_read_latency_r9: assert property (@(posedge clk) disable iff (busy)
            (rd_en && !empty) |=> data_valid)
            else $error("standard read produced no data");

         // R4: a read while empty does not move the read pointer
         p_no_underflow_move_r4: assert property (@(posedge clk) disable iff (busy)
            (rd_en && empty) |=> $stable(ptr))
            else $error("read while empty moved the pointer");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (busy) underflow <= 1'b0;
      else      underflow <= rd_en && empty;
   end

   assign almost_empty = (count == PW'(1));
   assign prog_empty   = (count <= PE_V);

   // R4: a read while empty is flagged on the following cycle
   p_underflow_flag_r4: assert property (@(posedge clk) disable iff (busy)
      (rd_en && empty) |=> underflow)
      else $error("underflow not flagged");

   // R2: the read side never sees more than the total capacity
   p_rd_count_bound_r2: assert property (@(posedge clk) disable iff (busy)
      count <= CAP_V)
      else $error("read-side count beyond capacity");
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
   import dcf_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int DEPTH        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit FWFT         = 1'b0,
   parameter int PFULL_TH     = 12,
   parameter int PEMPTY_TH    = 4,
   parameter bit FULL_RST_VAL = 1'b0
) (
   input  logic                       wr_clk,
   input  logic                       rd_clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   output logic                       full,
   output logic                       almost_full,
   output logic                       prog_full,
   output logic                       overflow,
   output logic                       wr_ack,
   output logic [$clog2(DEPTH):0]     wr_count,
   output logic                       wr_rst_busy,
   input  logic                       rd_en,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       data_valid,
   output logic                       empty,
   output logic                       almost_empty,
   output logic                       prog_empty,
   output logic                       underflow,
   output logic [$clog2(DEPTH):0]     rd_count,
   output logic                       rd_rst_busy
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PW     = ADDR_W + 1;
   localparam int LIMIT  = int'(wr_limit(DEPTH, FWFT));
   localparam int CAP    = int'(total_cap(DEPTH, FWFT));

   // Elaboration-time parameter checks
   if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 8) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 2..8");
   end
   if (PFULL_TH < 1 || PFULL_TH > LIMIT) begin : g_bad_pfull
      $error("PFULL_TH outside 1..write limit");
   end
   if (PEMPTY_TH < 0 || PEMPTY_TH >= CAP) begin : g_bad_pempty
      $error("PEMPTY_TH outside 0..capacity-1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic            wr_busy;
   logic            rd_busy;
   logic [PW-1:0]   wr_ptr;
   logic [PW-1:0]   rd_ptr;
   logic [PW-1:0]   wr_ptr_s;
   logic [PW-1:0]   rd_ptr_s;
   logic            wr_accept;
   logic [DATA_W-1:0] mem_rdata;

   dcf_reset_hs #(.STAGES(SYNC_STAGES)) u_rst_hs (
      .wr_clk  (wr_clk),
      .rd_clk  (rd_clk),
      .rst     (rst),
      .wr_busy (wr_busy),
      .rd_busy (rd_busy)
   );

   dcf_ptr_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
      .src_clk (wr_clk),
      .src_rst (wr_busy),
      .src_bin (wr_ptr),
      .dst_clk (rd_clk),
      .dst_rst (rd_busy),
      .dst_bin (wr_ptr_s)
   );

   dcf_ptr_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
      .src_clk (rd_clk),
      .src_rst (rd_busy),
      .src_bin (rd_ptr),
      .dst_clk (wr_clk),
      .dst_rst (wr_busy),
      .dst_bin (rd_ptr_s)
   );

   dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wr_clk (wr_clk),
      .we     (wr_accept),
      .waddr  (wr_ptr[ADDR_W-1:0]),
      .wdata  (wr_data),
      .raddr  (rd_ptr[ADDR_W-1:0]),
      .rdata  (mem_rdata)
   );

   dcf_wr_ctl #(
      .ADDR_W   (ADDR_W),
      .LIMIT    (LIMIT),
      .PFULL_TH (PFULL_TH),
      .FULL_RST (FULL_RST_VAL)
   ) u_wr (
      .clk         (wr_clk),
      .busy        (wr_busy),
      .wr_en       (wr_en),
      .rd_ptr_s    (rd_ptr_s),
      .ptr         (wr_ptr),
      .accept      (wr_accept),
      .full        (full),
      .almost_full (almost_full),
      .prog_full   (prog_full),
      .overflow    (overflow),
      .wr_ack      (wr_ack),
      .count       (wr_count)
   );

   dcf_rd_ctl #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .FWFT      (FWFT),
      .CAP       (CAP),
      .PEMPTY_TH (PEMPTY_TH)
   ) u_rd (
      .clk          (rd_clk),
      .busy         (rd_busy),
      .rd_en        (rd_en),
      .wr_ptr_s     (wr_ptr_s),
      .mem_rdata    (mem_rdata),
      .ptr          (rd_ptr),
      .rd_data      (rd_data),
      .data_valid   (data_valid),
      .empty        (empty),
      .almost_empty (almost_empty),
      .prog_empty   (prog_empty),
      .underflow    (underflow),
      .count        (rd_count)
   );

   assign wr_rst_busy = wr_busy;
   assign rd_rst_busy = rd_busy;

   // R11: full-side flags carry the reset value while the write side is busy
   p_full_reset_value_r11: assert property (@(posedge wr_clk)
      wr_busy |-> (full == FULL_RST_VAL && prog_full == FULL_RST_VAL))
      else $error("full flags not at reset value");
endmodule

// File: tb/dual_clock_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb_top;
   localparam int DW      = 32;
   localparam int DEPTH   = 16;
   localparam int PFULL   = 12;
   localparam int PEMPTY  = 4;
   localparam int CW      = $clog2(DEPTH) + 1;

   logic wr_clk = 1'b0;
   logic rd_clk = 1'b0;
   always #2.0 wr_clk = ~wr_clk;
   always #3.5 rd_clk = ~rd_clk;

   logic          rst = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   bit            fwft_mode = 1'b0;

   logic          s_full, s_af, s_pf, s_ovf, s_ack, s_wbusy, s_dv, s_empty, s_ae, s_pe, s_udf, s_rbusy;
   logic          f_full, f_af, f_pf, f_ovf, f_ack, f_wbusy, f_dv, f_empty, f_ae, f_pe, f_udf, f_rbusy;
   logic [CW-1:0] s_wcnt, s_rcnt, f_wcnt, f_rcnt;
   logic [DW-1:0] s_rdata, f_rdata;

   dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2), .FWFT(1'b0),
                     .PFULL_TH(PFULL), .PEMPTY_TH(PEMPTY), .FULL_RST_VAL(1'b0)) dut_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
      .wr_en(wr_en && !fwft_mode), .wr_data(wr_data),
      .full(s_full), .almost_full(s_af), .prog_full(s_pf), .overflow(s_ovf),
      .wr_ack(s_ack), .wr_count(s_wcnt), .wr_rst_busy(s_wbusy),
      .rd_en(rd_en && !fwft_mode), .rd_data(s_rdata), .data_valid(s_dv),
      .empty(s_empty), .almost_empty(s_ae), .prog_empty(s_pe), .underflow(s_udf),
      .rd_count(s_rcnt), .rd_rst_busy(s_rbusy));

   dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2), .FWFT(1'b1),
                     .PFULL_TH(PFULL), .PEMPTY_TH(PEMPTY), .FULL_RST_VAL(1'b0)) dut_fwft_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
      .wr_en(wr_en && fwft_mode), .wr_data(wr_data),
      .full(f_full), .almost_full(f_af), .prog_full(f_pf), .overflow(f_ovf),
      .wr_ack(f_ack), .wr_count(f_wcnt), .wr_rst_busy(f_wbusy),
      .rd_en(rd_en && fwft_mode), .rd_data(f_rdata), .data_valid(f_dv),
      .empty(f_empty), .almost_empty(f_ae), .prog_empty(f_pe), .underflow(f_udf),
      .rd_count(f_rcnt), .rd_rst_busy(f_rbusy));

   wire          o_full  = fwft_mode ? f_full  : s_full;
   wire          o_af    = fwft_mode ? f_af    : s_af;
   wire          o_pf    = fwft_mode ? f_pf    : s_pf;
   wire          o_ovf   = fwft_mode ? f_ovf   : s_ovf;
   wire          o_ack   = fwft_mode ? f_ack   : s_ack;
   wire          o_wbusy = fwft_mode ? f_wbusy : s_wbusy;
   wire          o_dv    = fwft_mode ? f_dv    : s_dv;
   wire          o_empty = fwft_mode ? f_empty : s_empty;
   wire          o_ae    = fwft_mode ? f_ae    : s_ae;
   wire          o_pe    = fwft_mode ? f_pe    : s_pe;
   wire          o_udf   = fwft_mode ? f_udf   : s_udf;
   wire          o_rbusy = fwft_mode ? f_rbusy : s_rbusy;
   wire [CW-1:0] o_wcnt  = fwft_mode ? f_wcnt  : s_wcnt;
   wire [CW-1:0] o_rcnt  = fwft_mode ? f_rcnt  : s_rcnt;
   wire [DW-1:0] o_rdata = fwft_mode ? f_rdata : s_rdata;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [DW-1:0] sb_q [$];
   int cap_w;
   int cap_t;
   int seq_no = 0;

   task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s (fwft=%0d): actual %0h expected %0h", req, what, fwft_mode, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(4.0 * 190000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         summary();
      end
   end

   task automatic check_wr_flags(input int n);
      chk("R12", "wr_count", DW'(o_wcnt), DW'(n));
      chk("R2",  "full", DW'(o_full), DW'(n >= cap_w));
      chk("R7",  "almost_full", DW'(o_af), DW'(n == cap_w - 1));
      chk("R6",  "prog_full", DW'(o_pf), DW'(n >= PFULL));
   endtask

   task automatic check_rd_flags(input int n);
      chk("R12", "rd_count", DW'(o_rcnt), DW'(n));
      chk("R4",  "empty", DW'(o_empty), DW'(n == 0));
      chk("R7",  "almost_empty", DW'(o_ae), DW'(n == 1));
      chk("R6",  "prog_empty", DW'(o_pe), DW'(n <= PEMPTY));
   endtask

   // Driver: pushes the expected word when the write is meant to be accepted
   task automatic write_one(input logic [DW-1:0] d, input bit expect_ok);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge wr_clk);
      wr_en = 1'b0;
      if (expect_ok) sb_q.push_back(d);
      chk("R5", "wr_ack", DW'(o_ack), DW'(expect_ok));
      chk("R3", "overflow", DW'(o_ovf), DW'(!expect_ok));
   endtask

   task automatic read_one();
      logic [DW-1:0] exp;
      exp = sb_q.pop_front();
      if (fwft_mode) begin
         chk("R8", "head valid before read", DW'(o_dv), DW'(1));
         chk("R8", "head word", o_rdata, exp);
         rd_en = 1'b1;
         @(negedge rd_clk);
         rd_en = 1'b0;
      end else begin
         rd_en = 1'b1;
         @(negedge rd_clk);
         rd_en = 1'b0;
         chk("R9", "data_valid after read", DW'(o_dv), DW'(1));
         chk("R1", "read order", o_rdata, exp);
      end
   endtask

   task automatic apply_reset(input int hold);
      bit saw_rd;
      bit order_bad;
      saw_rd    = 1'b0;
      order_bad = 1'b0;
      @(negedge wr_clk);
      rst = 1'b1;
      @(negedge wr_clk);
      chk("R10", "wr_rst_busy in reset", DW'(o_wbusy), DW'(1));
      chk("R11", "full in reset", DW'(o_full), DW'(0));
      chk("R11", "almost_full in reset", DW'(o_af), DW'(0));
      chk("R11", "prog_full in reset", DW'(o_pf), DW'(0));
      repeat (hold) @(negedge wr_clk);
      rst = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (o_rbusy) saw_rd = 1'b1;
         if (!o_wbusy && o_rbusy) order_bad = 1'b1;
         if (!o_wbusy && saw_rd) break;
         @(negedge wr_clk);
      end
      chk("R10", "rd_rst_busy raised", DW'(saw_rd), DW'(1));
      chk("R10", "write busy outlasts read busy", DW'(order_bad), DW'(0));
      chk("R10", "wr_rst_busy released", DW'(o_wbusy), DW'(0));
      repeat (8) @(negedge rd_clk);
      chk("R10", "rd_rst_busy released", DW'(o_rbusy), DW'(0));
      chk("R10", "empty after reset", DW'(o_empty), DW'(1));
      chk("R10", "prog_empty after reset", DW'(o_pe), DW'(1));
      chk("R10", "data_valid after reset", DW'(o_dv), DW'(0));
      chk("R10", "rd_count after reset", DW'(o_rcnt), DW'(0));
      chk("R10", "wr_count after reset", DW'(o_wcnt), DW'(0));
      sb_q.delete();
   endtask

   task automatic read_when_empty();
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      chk("R4", "underflow pulse", DW'(o_udf), DW'(1));
      chk("R4", "empty held", DW'(o_empty), DW'(1));
      chk("R4", "rd_count held", DW'(o_rcnt), DW'(0));
      chk("R9", "no data_valid on dropped read", DW'(o_dv), DW'(0));
      @(negedge rd_clk);
      chk("R4", "underflow one cycle", DW'(o_udf), DW'(0));
   endtask

   task automatic stream(input int wr_cycles);
      bit wdone;
      int bad_flag;
      wdone    = 1'b0;
      bad_flag = 0;
      fork
         begin : writer
            for (int i = 0; i < wr_cycles; i++) begin
               bit go;
               go = ($urandom_range(0, 3) != 0) && !o_full;
               wr_en = go;
               if (go) begin
                  wr_data = {fwft_mode, 7'h55, 24'(seq_no)};
                  seq_no++;
                  sb_q.push_back(wr_data);
               end
               @(negedge wr_clk);
               wr_en = 1'b0;
               if (o_ack !== go || o_ovf !== 1'b0) bad_flag++;
            end
            wdone = 1'b1;
         end
         begin : monitor
            int guard;
            guard = 0;
            @(negedge rd_clk);
            while (!(wdone && sb_q.size() == 0 && !rd_en) && guard < 40000) begin
               bit take;
               guard++;
               if (!fwft_mode && o_dv) chk("R1", "stream order", o_rdata, sb_q.pop_front());
               if (o_udf !== 1'b0) bad_flag++;
               take = ($urandom_range(0, 2) != 0) && !o_empty;
               if (take && fwft_mode) chk("R8", "stream head", o_rdata, sb_q.pop_front());
               rd_en = take;
               @(negedge rd_clk);
               rd_en = 1'b0;
            end
            if (!fwft_mode && o_dv) chk("R1", "stream last", o_rdata, sb_q.pop_front());
         end
      join
      chk("R5", "stream ack/overflow/underflow mismatches", DW'(bad_flag), DW'(0));
      chk("R1", "stream scoreboard drained", DW'(sb_q.size()), DW'(0));
   endtask

   task automatic run_mode(input bit f);
      int n;
      fwft_mode = f;
      cap_w = f ? DEPTH : DEPTH - 1;
      cap_t = f ? DEPTH + 1 : DEPTH - 1;

      apply_reset(4);
      read_when_empty();

      // Fill to capacity, flags checked at every step
      @(negedge wr_clk);
      write_one({f, 7'h11, 24'(seq_no)}, 1'b1); seq_no++;
      repeat (30) @(negedge wr_clk);
      n = f ? 0 : 1;
      check_wr_flags(n);
      for (int k = 1; k < cap_t; k++) begin
         write_one({f, 7'h11, 24'(seq_no)}, 1'b1); seq_no++;
         n++;
         check_wr_flags(n);
      end
      chk("R2", "full at capacity", DW'(o_full), DW'(1));

      // Write while full
      write_one(32'hDEAD_BEEF, 1'b0);
      @(negedge wr_clk);
      chk("R3", "overflow one cycle", DW'(o_ovf), DW'(0));
      check_wr_flags(cap_w);

      // Drain, read-side flags checked at every step
      repeat (30) @(negedge rd_clk);
      n = cap_t;
      check_rd_flags(n);
      for (int k = 0; k < cap_t; k++) begin
         read_one();
         n--;
         check_rd_flags(n);
      end
      read_when_empty();
      repeat (30) @(negedge wr_clk);
      check_wr_flags(0);

      // Random traffic on unrelated clocks
      stream(2500);
      repeat (30) @(negedge rd_clk);
      check_rd_flags(0);

      // Short reset pulse in the middle of stored data
      @(negedge wr_clk);
      for (int k = 0; k < 5; k++) begin
         write_one({f, 7'h22, 24'(k)}, 1'b1);
      end
      repeat (30) @(negedge wr_clk);
      apply_reset(0);
      repeat (10) @(negedge rd_clk);
      check_rd_flags(0);
   endtask

   initial begin
      rst = 1'b1;
      repeat (6) @(negedge wr_clk);
      rst = 1'b0;
      run_mode(1'b0);
      run_mode(1'b1);
      done = 1'b1;
      summary();
   end
endmodule